// File: doc/BRIEF.md
# Two-Plane Cached Page Program Sequencer

This block is the host-side engine that writes one page into each of the two planes of a NAND-style flash device in a single cached program step. It is given a request with two row addresses, a start column, a byte count and a flag that marks the final pair of a cached series. It first checks that the rows sit in the correct planes. It then loads the plane-0 page and closes it with the dummy confirm. Once the device reports ready again, it loads the plane-1 page and closes it with the cache confirm. Last, it reads the status byte until the device shows it can accept more work, and it reports the pass/fail bits from that byte.

Payload bytes come from a streaming source, one byte per write strobe. The block pulls a byte from the source in the same cycle it drives that byte onto the bus. Only `len` bytes are loaded, starting at column `col`, so a page can be filled only in part. Every wait on the ready/busy line and every status poll loop is limited by a programmable timeout.

Top module: `mpcache_seq`

## Requirements
- R1: A request is rejected when bit PLANE_BIT (default 6) of `row0` is 1 or the same bit of `row1` is 0. In that case `err_plane` is set, `done` pulses, and no write or read strobe is issued.
- R2: The first page is sent as: command 80h with `cle` high; five address bytes with `ale` high (column bits 7:0, column bits 15:8, row bits 7:0, 15:8, 23:16, zero-extended); `len` data bytes with `cle` and `ale` low; then command 11h.
- R3: Each bus byte is latched by `we_n` going low for exactly one clock and then high for at least one clock. `cle` and `ale` are never high together, and `we_n` and `re_n` are never low together.
- R4: After 11h the block waits until `rb` is high, ignoring it for the first two clocks. It then sends 81h, the five address bytes of `row1` (same byte order, same column), the `len` data bytes, and command 15h. No byte of the second page goes out before `rb` has returned high.
- R5: `src_take` is high exactly in the cycles in which a data byte from `src_byte` is on `dq` with `we_n` low. A request therefore takes 2*`len` source bytes, and `len` = 0 sends no data cycles.
- R6: After 15h and the following ready wait, the block sends 70h and then reads the status with one-clock `re_n` pulses. It stops at the first read in which the poll bit is 1. The poll bit is status bit 6 when `last` is 0 and status bit 5 when `last` is 1.
- R7: At completion, `err_fail` equals bit 0 and `err_prev` equals bit 1 of the status byte from the final read.
- R8: If `rb` is not seen high within `tmo_limit` clocks of a wait, `err_timeout` is set, `done` pulses, and no further strobe is issued.
- R9: If `tmo_limit` status reads in a row show the poll bit as 0, `err_timeout` is set after exactly that many reads, and `done` pulses.
- R10: `done` is high for one clock per accepted request. The error flags keep their values until the next accepted `start`. A `start` while `busy` is high is ignored, and so are changes on the request inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken when idle |
| last | input | 1 | Final pair of a cached series |
| row0 | input | ROW_W | Row address of the plane-0 page |
| row1 | input | ROW_W | Row address of the plane-1 page |
| col | input | COL_W | Start column for both pages |
| len | input | LEN_W | Bytes loaded per page |
| tmo_limit | input | TO_W | Limit for each ready wait (clocks) and each poll loop (reads) |
| rb | input | 1 | Device ready (1) or busy (0) |
| status | input | 8 | Device status byte, sampled at the end of a read pulse |
| src_byte | input | 8 | Next payload byte from the source |
| src_take | output | 1 | Payload byte consumed this cycle |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq | output | 8 | Bus data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| err_plane | output | 1 | Plane check failed |
| err_timeout | output | 1 | Ready wait or poll loop timed out |
| err_fail | output | 1 | Status bit 0 at completion |
| err_prev | output | 1 | Status bit 1 at completion |

## Verification
The assertions check the bus hygiene of R3 on every cycle: a single-clock write pulse, no overlap of the latch enables, and no overlap of the read and write strobes. They also check the one-cycle `done` pulse, the immediate rejection on a plane mismatch, the bound on the wait counter, and that the source is only pulled during data cycles. Several things can only be shown by the bench scenarios with a device model that returns busy and status: the exact byte order and the data payload, the hold-off of the second page until ready returns, the choice of poll bit by `last`, the exact number of status reads, and the error bits taken from the final read.

// File: rtl/mpcache_seq.sv
module mpcache_seq #(
  parameter int COL_W     = 12,
  parameter int ROW_W     = 18,
  parameter int PLANE_BIT = 6,
  parameter int LEN_W     = 12,
  parameter int TO_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             last,
  input  logic [ROW_W-1:0] row0,
  input  logic [ROW_W-1:0] row1,
  input  logic [COL_W-1:0] col,
  input  logic [LEN_W-1:0] len,
  input  logic [TO_W-1:0]  tmo_limit,
  input  logic             rb,
  input  logic [7:0]       status,
  input  logic [7:0]       src_byte,
  output logic             src_take,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [7:0]       dq,
  output logic             busy,
  output logic             done,
  output logic             err_plane,
  output logic             err_timeout,
  output logic             err_fail,
  output logic             err_prev
);

  localparam logic [7:0] C_LOAD1 = 8'h80;
  localparam logic [7:0] C_LOAD2 = 8'h81;
  localparam logic [7:0] C_DUMMY = 8'h11;
  localparam logic [7:0] C_CACHE = 8'h15;
  localparam logic [7:0] C_STAT  = 8'h70;
  localparam int         AW      = (LEN_W > 3) ? LEN_W : 3;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADR, S_DAT, S_WAIT, S_POLL, S_DONE} st_t;

  st_t              st;
  logic             ph, plane_q, last_q;
  logic [7:0]       cmd_q;
  logic [AW-1:0]    idx;
  logic [TO_W-1:0]  cnt, tmo_q;
  logic [ROW_W-1:0] r0_q, r1_q;
  logic [COL_W-1:0] col_q;
  logic [LEN_W-1:0] len_q;
  logic [39:0]      addr5;
  logic             poll_bit;

  assign addr5    = {24'(plane_q ? r1_q : r0_q), 16'(col_q)};
  assign poll_bit = last_q ? status[5] : status[6];
  assign cle      = (st == S_CMD);
  assign ale      = (st == S_ADR);
  assign we_n     = !((st == S_CMD || st == S_ADR || st == S_DAT) && !ph);
  assign re_n     = !((st == S_POLL) && !ph);
  assign src_take = (st == S_DAT) && !ph;
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);

  always_comb begin
    case (st)
      S_CMD:   dq = cmd_q;
      S_ADR:   dq = addr5[8*idx[2:0] +: 8];
      S_DAT:   dq = src_byte;
      default: dq = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 1'b0; plane_q <= 1'b0; last_q <= 1'b0;
      cmd_q <= 8'h00; idx <= '0; cnt <= '0; tmo_q <= '0;
      r0_q <= '0; r1_q <= '0; col_q <= '0; len_q <= '0;
      err_plane <= 1'b0; err_timeout <= 1'b0; err_fail <= 1'b0; err_prev <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          err_plane <= 1'b0; err_timeout <= 1'b0; err_fail <= 1'b0; err_prev <= 1'b0;
          r0_q <= row0; r1_q <= row1; col_q <= col; len_q <= len;
          last_q <= last; tmo_q <= tmo_limit; ph <= 1'b0; plane_q <= 1'b0;
          if (row0[PLANE_BIT] || !row1[PLANE_BIT]) begin
            err_plane <= 1'b1;
            st        <= S_DONE;
          end else begin
            cmd_q <= C_LOAD1;
            st    <= S_CMD;
          end
        end
        S_CMD: begin
          ph <= ~ph;
          if (ph) begin
            idx <= '0;
            cnt <= '0;
            if (cmd_q == C_LOAD1 || cmd_q == C_LOAD2) st <= S_ADR;
            else if (cmd_q == C_STAT)                 st <= S_POLL;
            else                                       st <= S_WAIT;
          end
        end
        S_ADR: begin
          ph <= ~ph;
          if (ph) begin
            if (idx == AW'(4)) begin
              idx <= '0;
              if (len_q == '0) begin
                cmd_q <= plane_q ? C_CACHE : C_DUMMY;
                st    <= S_CMD;
              end else begin
                st <= S_DAT;
              end
            end else begin
              idx <= idx + AW'(1);
            end
          end
        end
        S_DAT: begin
          ph <= ~ph;
          if (ph) begin
            if (idx == AW'(len_q - LEN_W'(1))) begin
              cmd_q <= plane_q ? C_CACHE : C_DUMMY;
              st    <= S_CMD;
            end else begin
              idx <= idx + AW'(1);
            end
          end
        end
        S_WAIT: begin
          if (cnt >= TO_W'(2) && rb) begin
            if (!plane_q) begin
              plane_q <= 1'b1;
              cmd_q   <= C_LOAD2;
            end else begin
              cmd_q <= C_STAT;
            end
            st <= S_CMD;
          end else if (cnt >= tmo_q) begin
            err_timeout <= 1'b1;
            st          <= S_DONE;
          end else begin
            cnt <= cnt + TO_W'(1);
          end
        end
        S_POLL: begin
          ph <= ~ph;
          if (!ph) begin
            if (poll_bit) begin
              err_fail <= status[0];
              err_prev <= status[1];
              ph       <= 1'b0;
              st       <= S_DONE;
            end else if ((TO_W+1)'(cnt) + (TO_W+1)'(1) >= (TO_W+1)'(tmo_q)) begin
              err_timeout <= 1'b1;
              ph          <= 1'b0;
              st          <= S_DONE;
            end else begin
              cnt <= cnt + TO_W'(1);
            end
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r3_we_single: assert property (@(posedge clk) disable iff (!rst_n) !we_n |=> we_n);
  a_r3_latch_excl: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n));
  a_r1_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && (row0[PLANE_BIT] || !row1[PLANE_BIT])) |=> (done && err_plane && we_n && re_n));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r5_take_in_data: assert property (@(posedge clk) disable iff (!rst_n) src_take |-> (!we_n && !cle && !ale));
  a_r8_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n) (st == S_WAIT) |-> (cnt <= tmo_q));

endmodule

// File: tb/test_mpcache_seq.sv
module test_mpcache_seq;
  localparam int NEVER = 1000000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, last = 1'b0, rb = 1'b1;
  logic [17:0] row0 = '0, row1 = '0;
  logic [11:0] col = '0, len = '0;
  logic [15:0] tmo_limit = '0;
  logic [7:0]  status = 8'h00, src_byte;
  logic src_take, cle, ale, we_n, re_n, busy, done;
  logic err_plane, err_timeout, err_fail, err_prev;
  logic [7:0] dq;

  int n = 0, tk = 0, reads = 0, bsy = 0, cyc = 0;
  int busy_len = 4, rdy_after = 1;
  logic [7:0] st_rdy = 8'h60, st_not = 8'h00;
  int log_v[0:63];
  int log_t[0:63];
  int vec = 0, bad = 0;

  always #4 clk = ~clk;
  assign src_byte = 8'(tk * 7 + 3);

  mpcache_seq i_mpcache_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .last(last), .row0(row0), .row1(row1),
    .col(col), .len(len), .tmo_limit(tmo_limit), .rb(rb), .status(status),
    .src_byte(src_byte), .src_take(src_take), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .dq(dq), .busy(busy), .done(done), .err_plane(err_plane),
    .err_timeout(err_timeout), .err_fail(err_fail), .err_prev(err_prev));

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (bsy > 0) begin
      bsy = bsy - 1;
      if (bsy == 0) rb = 1'b1;
    end
    if (!we_n) begin
      if (n < 64) begin
        log_v[n] = {22'd0, cle, ale, dq};
        log_t[n] = cyc;
      end
      n = n + 1;
      if (cle && (dq == 8'h11 || dq == 8'h15) && busy_len > 0) begin
        bsy = busy_len;
        rb  = 1'b0;
      end
      if (src_take) tk = tk + 1;
    end
    if (!re_n) begin
      reads  = reads + 1;
      status = (reads >= rdy_after) ? st_rdy : st_not;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    vec = vec + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  task automatic run(int r0, int r1, int c, int ln, bit lst, int bl, int ra,
                     logic [7:0] sr, int tmo, bit poke, output bit seen);
    seen = 1'b0;
    @(negedge clk);
    n = 0; tk = 0; reads = 0; bsy = 0; rb = 1'b1;
    busy_len = bl; rdy_after = ra; st_rdy = sr;
    st_not = lst ? ((sr & 8'hDF) | 8'h40) : ((sr & 8'hBF) | 8'h20);
    row0 = 18'(r0); row1 = 18'(r1); col = 12'(c); len = 12'(ln);
    last = lst; tmo_limit = 16'(tmo); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4000 && !seen; k++) begin
      if (poke && k == 10) begin
        start = 1'b1; row0 = 18'(r0 ^ 32'h40); row1 = 18'(r1 ^ 32'h5A5);
      end else if (poke && k == 11) begin
        start = 1'b0;
      end
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic check_seq(int r0, int r1, int c, int ln, int upto);
    int e[0:63];
    int m = 0;
    e[m++] = 'h280;
    for (int i = 0; i < 5; i++) e[m++] = 'h100 | ((i < 2) ? ((c >> (8*i)) & 255) : ((r0 >> (8*(i-2))) & 255));
    for (int i = 0; i < ln; i++) e[m++] = (i * 7 + 3) & 255;
    e[m++] = 'h211;
    e[m++] = 'h281;
    for (int i = 0; i < 5; i++) e[m++] = 'h100 | ((i < 2) ? ((c >> (8*i)) & 255) : ((r1 >> (8*(i-2))) & 255));
    for (int i = 0; i < ln; i++) e[m++] = ((ln + i) * 7 + 3) & 255;
    e[m++] = 'h215;
    e[m++] = 'h270;
    if (upto < m) m = upto;
    check(n == m, "R2/R4 byte count", n, m);
    for (int i = 0; i < m && i < n; i++)
      check(log_v[i] == e[i], (i <= 6 + ln) ? "R2 first page byte" : "R4 second page byte", log_v[i], e[i]);
  endtask

  initial begin
    bit seen;
    int r0, r1, c, pos11, pos81;
    logic [7:0] sr;
    fork
      begin
        repeat (150000) @(posedge clk);
        bad = bad + 1;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_run();
      end
    join_none

    repeat (3) @(negedge clk);
    check(we_n && re_n && !cle && !ale && !busy && !done, "R3 reset idle", {we_n, re_n, cle, ale}, 4'b1100);
    rst_n = 1'b1;
    @(negedge clk);

    for (int ln = 0; ln < 5; ln++) begin
      for (int lst = 0; lst < 2; lst++) begin
        r0 = (ln * 'h1235 + 'h20304) & 'h3FFBF;
        r1 = ((ln * 'h0A31 + 'h10507) & 'h3FFFF) | 'h40;
        c  = (ln * 'h2C5 + 'h0A1) & 'hFFF;
        sr = 8'(((ln + lst) & 3) | 'h60);
        run(r0, r1, c, ln, lst[0], 3 + ln, 1 + ((ln + lst) % 3), sr, 200, (ln == 2), seen);
        check(seen, "R10 done pulse", seen, 1);
        check_seq(r0, r1, c, ln, 64);
        check(tk == 2 * ln, "R5 source bytes", tk, 2 * ln);
        check(reads == 1 + ((ln + lst) % 3), "R6 poll reads", reads, 1 + ((ln + lst) % 3));
        check(err_fail == sr[0] && err_prev == sr[1], "R7 status bits", {err_prev, err_fail}, sr[1:0]);
        check(!err_timeout && !err_plane, "R8 no error", {err_timeout, err_plane}, 0);
        pos11 = 6 + ln; pos81 = 7 + ln;
        check(log_t[pos81] - log_t[pos11] > 3 + ln, "R4 waits for ready", log_t[pos81] - log_t[pos11], 4 + ln);
        @(negedge clk);
        check(!done, "R10 done one clock", done, 0);
        repeat (4) @(negedge clk);
        check(err_fail == sr[0] && err_prev == sr[1] && !busy, "R10 flags held", {err_prev, err_fail}, sr[1:0]);
        check(n == 15 + 2 * ln, "R3 no stray strobes", n, 15 + 2 * ln);
      end
    end

    for (int k = 0; k < 3; k++) begin
      r0 = (k == 1) ? 'h00010 : 'h00050;
      r1 = (k == 0) ? 'h00050 : 'h00010;
      run(r0, r1, 'h12, 2, 1'b0, 3, 1, 8'h60, 100, 1'b0, seen);
      check(seen && err_plane, "R1 plane reject", {seen, err_plane}, 2'b11);
      repeat (3) @(negedge clk);
      check(n == 0 && reads == 0 && tk == 0, "R1 no bus cycles", n + reads, 0);
    end

    run('h00100, 'h00140, 'h7, 2, 1'b0, NEVER, 1, 8'h60, 20, 1'b0, seen);
    check(seen && err_timeout, "R8 wait timeout", err_timeout, 1);
    repeat (5) @(negedge clk);
    check(n == 9, "R8 stops after 11h", n, 9);
    check_seq('h00100, 'h00140, 'h7, 2, 9);

    run('h00200, 'h00240, 'h9, 1, 1'b1, 2, 1000, 8'h60, 5, 1'b0, seen);
    check(seen && err_timeout, "R9 poll timeout", err_timeout, 1);
    check(reads == 5, "R9 poll read count", reads, 5);

    run('h00300, 'h00340, 'h3, 1, 1'b0, 2, 2, 8'h40, 50, 1'b0, seen);
    check(seen && !err_timeout && !err_plane, "R10 flags cleared on start", {err_timeout, err_plane}, 0);

    finish_run();
  end
endmodule